// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core from normal execution into an exception handler. It accepts four request lines: a non-maskable interrupt, a bus fault, a break trap and an external interrupt. It picks the winning request and takes a snapshot of the architectural state it needs. It then runs a fixed sequence of cycles. In the first cycle it emits write strobes and values for the return-address registers, the stack pointers, the status word and the exception status word. In the next phase it fetches the handler address from a vector table in memory, and it finishes by loading that address into the program counter.

The sequencer has two behaviour sets, chosen by a version number that is sampled with the request. In the current set, the status word shifts its flag history up by one field. The vector number is recorded in an exception status word, and a pending delay slot winds the return address back so the branch runs again. In the legacy set none of those three things happens. Instead, an interrupt-lock flag is set, and a bus fault is reported as illegal.

Top module: `exc_entry_seq`

## Requirements
- R1: When several request lines are high in the same accepting cycle, the winner is chosen in this order: NMI, then bus fault, then break, then external interrupt. The vector used is 0 for NMI, `fault_vec` for a bus fault, `trap_vec` for a break and `irq_vec` for an external interrupt.
- R2: In the save cycle, an NMI pulses `nrp_we` and every other kind pulses `erp_we`. The two are never high together. `ret_val` is the sampled PC, minus the delay-slot count when the current set applies.
- R3: When bit 8 of the sampled status word (the user flag) is set, the save cycle pulses `usp_we` with the sampled SP and `sp_we` with the sampled kernel SP. Otherwise neither strobe pulses.
- R4: In the current set, the save cycle writes the status word as bits 31:30 unchanged, bits 29:10 taken from old bits 19:0, and bits 9:0 zero. For an NMI, bit 30 (the M flag) is cleared before this shift.
- R5: In the current set, the save cycle writes `exs_val` with the vector in bits 15:8 and zeros in all other bits.
- R6: In the current set, a nonzero delay-slot count pulses `dslot_clr` in the save cycle. A count of zero does not pulse it.
- R7: From the cycle after the save cycle, `vt_req` stays high with a stable `vt_addr` equal to `ebp_in` + 4 × vector, until the cycle in which `vt_rvalid` is seen.
- R8: The cycle after the response, `pc_we` pulses with `pc_val` equal to the returned word. `done` pulses for exactly one cycle on the cycle after that.
- R9: In the legacy set (`ver_in` < 32), the save cycle pulses `lock_set`. It does not write `exs` and does not rewind or clear the delay slot. The status word is written only for an NMI, and then only with the M flag cleared.
- R10: A bus fault in the legacy set pulses `illegal` in the save cycle with no other write strobe. The block then returns to idle with no table fetch.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle. Request lines that are high while busy are ignored.
- R12: During and right after reset, `busy`, `done`, `vt_req` and every write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_bus | input | 1 | Bus fault request |
| req_brk | input | 1 | Break trap request |
| req_irq | input | 1 | External interrupt request |
| trap_vec | input | 8 | Vector for a break trap |
| fault_vec | input | 8 | Vector for a bus fault, latched by translation |
| irq_vec | input | 8 | Vector from the interrupt controller |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ccs_in | input | 32 | Condition/status word |
| ebp_in | input | 32 | Vector table base |
| ver_in | input | 8 | Core version number |
| dslot_in | input | 2 | Pending delay-slot count |
| erp_we | output | 1 | Exception return register write |
| nrp_we | output | 1 | NMI return register write |
| ret_val | output | 32 | Return address value |
| usp_we | output | 1 | User SP write |
| usp_val | output | 32 | User SP value |
| sp_we | output | 1 | SP write |
| sp_val | output | 32 | SP value |
| ccs_we | output | 1 | Status word write |
| ccs_val | output | 32 | Status word value |
| exs_we | output | 1 | Exception status write |
| exs_val | output | 32 | Exception status value |
| dslot_clr | output | 1 | Clear delay-slot count |
| lock_set | output | 1 | Set interrupt lock |
| illegal | output | 1 | Illegal legacy bus fault |
| vt_req | output | 1 | Vector table read request |
| vt_addr | output | 32 | Vector table read address |
| vt_rvalid | input | 1 | Read response valid |
| vt_rdata | input | 32 | Read response word |
| pc_we | output | 1 | PC write |
| pc_val | output | 32 | New PC (handler address) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second request that arrives while a sequence is already running. It must leave no trace. The stimulus raises an external interrupt right after acceptance and holds it until the `done` cycle. The per-cycle model then requires that no second sequence follows. The other hard cases are priority under simultaneous requests and the legacy bus-fault abort. They are reached by setting `ver_in` below 32 and raising several lines in the same cycle. The response latency is varied, including zero wait cycles, so that the request-hold rule is seen at both of its extremes.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN = 32;
    localparam int VECW = 8;
    localparam int DSLW = 2;
    localparam int VERW = 8;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [VECW-1:0] vec_t;

    typedef enum logic [2:0] {EK_NONE, EK_NMI, EK_BUS, EK_BRK, EK_IRQ} exc_kind_t;
    typedef enum logic [2:0] {ST_IDLE, ST_SAVE, ST_FETCH, ST_LOAD, ST_DONE} seq_state_t;

    // State captured at acceptance
    typedef struct packed {
        exc_kind_t        kind;
        vec_t             vec;
        logic             new_mode;
        word_t            pc;
        word_t            sp;
        word_t            ksp;
        word_t            ccs;
        word_t            ebp;
        logic [DSLW-1:0]  dslot;
    } entry_ctx_t;

    // Updates emitted in the save cycle
    typedef struct packed {
        logic  illegal;
        logic  erp_we;
        logic  nrp_we;
        logic  stk_swap;
        logic  ccs_we;
        logic  exs_we;
        logic  dslot_clr;
        logic  lock_set;
        word_t ret_addr;
        word_t ccs_val;
        word_t exs_val;
    } entry_upd_t;

    // Flag history moves up one field; low ten bits cleared
    function automatic word_t ccs_shift(word_t old);
        return ((old & 32'hC000_0000) | ((old << 12) >> 2)) & ~32'h0000_03FF;
    endfunction

    function automatic word_t table_addr(word_t base, vec_t v);
        return base + (word_t'(v) << 2);
    endfunction
endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_entry_pkg::*;
(
    input  logic      nmi,
    input  logic      bus,
    input  logic      brk,
    input  logic      irq,
    input  vec_t      fault_vec,
    input  vec_t      trap_vec,
    input  vec_t      irq_vec,
    output exc_kind_t kind,
    output vec_t      vec
);
    always_comb begin
        kind = EK_NONE;
        vec  = '0;
        if (nmi) begin
            kind = EK_NMI;
        end else if (bus) begin
            kind = EK_BUS;
            vec  = fault_vec;
        end else if (brk) begin
            kind = EK_BRK;
            vec  = trap_vec;
        end else if (irq) begin
            kind = EK_IRQ;
            vec  = irq_vec;
        end
    end
endmodule

// File: rtl/exc_state_xform.sv
module exc_state_xform
    import exc_entry_pkg::*;
#(
    parameter int U_BIT = 8,
    parameter int M_BIT = 30
) (
    input  entry_ctx_t ctx,
    output entry_upd_t upd
);
    word_t ccs_m;
    logic  is_nmi;

    always_comb begin
        is_nmi = (ctx.kind == EK_NMI);
        ccs_m  = ctx.ccs;
        if (is_nmi) ccs_m[M_BIT] = 1'b0;

        upd = '0;
        if (!ctx.new_mode && ctx.kind == EK_BUS) begin
            upd.illegal = 1'b1;
        end else begin
            upd.ret_addr = ctx.new_mode ? ctx.pc - word_t'(ctx.dslot) : ctx.pc;
            upd.nrp_we   = is_nmi;
            upd.erp_we   = !is_nmi;
            upd.stk_swap = ctx.ccs[U_BIT];
            if (ctx.new_mode) begin
                upd.ccs_we    = 1'b1;
                upd.ccs_val   = ccs_shift(ccs_m);
                upd.exs_we    = 1'b1;
                upd.exs_val   = word_t'(ctx.vec) << 8;
                upd.dslot_clr = (ctx.dslot != '0);
            end else begin
                upd.ccs_we   = is_nmi;
                upd.ccs_val  = ccs_m;
                upd.lock_set = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       abort,
    input  logic       rsp_valid,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_SAVE;
            ST_SAVE:  nxt = abort ? ST_IDLE : ST_FETCH;
            ST_FETCH: if (rsp_valid) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int OLD_VER_LIMIT = 32,
    parameter int U_BIT         = 8,
    parameter int M_BIT         = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_nmi,
    input  logic            req_bus,
    input  logic            req_brk,
    input  logic            req_irq,
    input  logic [VECW-1:0] trap_vec,
    input  logic [VECW-1:0] fault_vec,
    input  logic [VECW-1:0] irq_vec,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] ksp_in,
    input  logic [XLEN-1:0] ccs_in,
    input  logic [XLEN-1:0] ebp_in,
    input  logic [VERW-1:0] ver_in,
    input  logic [DSLW-1:0] dslot_in,
    output logic            erp_we,
    output logic            nrp_we,
    output logic [XLEN-1:0] ret_val,
    output logic            usp_we,
    output logic [XLEN-1:0] usp_val,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_val,
    output logic            ccs_we,
    output logic [XLEN-1:0] ccs_val,
    output logic            exs_we,
    output logic [XLEN-1:0] exs_val,
    output logic            dslot_clr,
    output logic            lock_set,
    output logic            illegal,
    output logic            vt_req,
    output logic [XLEN-1:0] vt_addr,
    input  logic            vt_rvalid,
    input  logic [XLEN-1:0] vt_rdata,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_val,
    output logic            busy,
    output logic            done
);
    localparam logic [VERW-1:0] VER_LIM = VERW'(OLD_VER_LIMIT);

    exc_kind_t  win_kind;
    vec_t       win_vec;
    entry_ctx_t ctx;
    entry_upd_t upd;
    seq_state_t state;
    word_t      handler;
    logic       start, in_save;

    exc_req_arbiter u_arb (
        .nmi(req_nmi), .bus(req_bus), .brk(req_brk), .irq(req_irq),
        .fault_vec(fault_vec), .trap_vec(trap_vec), .irq_vec(irq_vec),
        .kind(win_kind), .vec(win_vec)
    );

    assign start   = (state == ST_IDLE) && (win_kind != EK_NONE);
    assign in_save = (state == ST_SAVE);

    exc_entry_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .abort(upd.illegal), .rsp_valid(vt_rvalid), .state(state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '0;
            handler <= '0;
        end else begin
            if (start) begin
                ctx.kind     <= win_kind;
                ctx.vec      <= win_vec;
                ctx.new_mode <= (ver_in >= VER_LIM);
                ctx.pc       <= pc_in;
                ctx.sp       <= sp_in;
                ctx.ksp      <= ksp_in;
                ctx.ccs      <= ccs_in;
                ctx.ebp      <= ebp_in;
                ctx.dslot    <= dslot_in;
            end
            if (state == ST_FETCH && vt_rvalid) handler <= vt_rdata;
        end
    end

    exc_state_xform #(.U_BIT(U_BIT), .M_BIT(M_BIT)) u_xf (
        .ctx(ctx), .upd(upd)
    );

    assign illegal   = in_save && upd.illegal;
    assign erp_we    = in_save && upd.erp_we;
    assign nrp_we    = in_save && upd.nrp_we;
    assign ret_val   = upd.ret_addr;
    assign usp_we    = in_save && upd.stk_swap;
    assign usp_val   = ctx.sp;
    assign sp_we     = in_save && upd.stk_swap;
    assign sp_val    = ctx.ksp;
    assign ccs_we    = in_save && upd.ccs_we;
    assign ccs_val   = upd.ccs_val;
    assign exs_we    = in_save && upd.exs_we;
    assign exs_val   = upd.exs_val;
    assign dslot_clr = in_save && upd.dslot_clr;
    assign lock_set  = in_save && upd.lock_set;

    assign vt_req  = (state == ST_FETCH);
    assign vt_addr = table_addr(ctx.ebp, ctx.vec);
    assign pc_we   = (state == ST_LOAD);
    assign pc_val  = handler;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
endmodule

// File: rtl/exc_entry_sva.sv
module exc_entry_sva (
    input logic        clk,
    input logic        rst,
    input logic        erp_we,
    input logic        nrp_we,
    input logic        ccs_we,
    input logic        exs_we,
    input logic        dslot_clr,
    input logic        lock_set,
    input logic        illegal,
    input logic        vt_req,
    input logic [31:0] vt_addr,
    input logic        vt_rvalid,
    input logic        pc_we,
    input logic        busy,
    input logic        done
);
    a_r2_one_return: assert property (@(posedge clk) disable iff (rst)
        !(erp_we && nrp_we));
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (vt_req && !vt_rvalid) |=> (vt_req && $stable(vt_addr)));
    a_r8_done_after_pc: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> done);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_legacy_no_exs: assert property (@(posedge clk) disable iff (rst)
        lock_set |-> (!exs_we && !dslot_clr));
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!erp_we && !nrp_we && !ccs_we && !exs_we));
    a_r10_illegal_idle: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !busy);
    a_r11_busy_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind exc_entry_seq exc_entry_sva chk_i (.*);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic req_nmi = 0, req_bus = 0, req_brk = 0, req_irq = 0;
    logic [7:0]  trap_vec = 0, fault_vec = 0, irq_vec = 0, ver_in = 0;
    logic [31:0] pc_in = 0, sp_in = 0, ksp_in = 0, ccs_in = 0, ebp_in = 0;
    logic [1:0]  dslot_in = 0;
    logic erp_we, nrp_we, usp_we, sp_we, ccs_we, exs_we, dslot_clr, lock_set, illegal;
    logic vt_req, pc_we, busy, done;
    logic [31:0] ret_val, usp_val, sp_val, ccs_val, exs_val, vt_addr, pc_val;
    logic vt_rvalid = 0;
    logic [31:0] vt_rdata = 0;

    exc_entry_seq dut_i (.*);

    int n_chk = 0, n_fail = 0;
    int lat = 1, wcnt = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Memory responder: answers after lat waiting cycles
    always @(negedge clk) begin
        if (vt_rvalid) begin
            vt_rvalid = 0;
            wcnt = 0;
        end else if (vt_req === 1'b1) begin
            if (wcnt >= lat) begin
                vt_rvalid = 1;
                vt_rdata  = vt_addr ^ 32'h5A00_00F0;
            end else wcnt++;
        end
    end

    // Behavioural reference model
    int m_phase = 0;
    bit m_ill, m_nrp, m_swap, m_ccs_we, m_exs_we, m_dclr, m_lock, m_new;
    logic [31:0] m_ret, m_usp, m_sp, m_ccs, m_exs, m_addr, m_hdl;

    always @(posedge clk) begin
        if (rst) m_phase = 0;
        else case (m_phase)
            0: if (req_nmi | req_bus | req_brk | req_irq) begin
                logic [7:0] v;
                logic [31:0] cm;
                v = req_nmi ? 8'd0 : req_bus ? fault_vec : req_brk ? trap_vec : irq_vec;
                m_new = (ver_in >= 32);
                m_nrp = req_nmi;
                m_ill = !m_new && !req_nmi && req_bus;
                m_ret = m_new ? pc_in - 32'(dslot_in) : pc_in;
                m_swap = ccs_in[8];
                m_usp = sp_in; m_sp = ksp_in;
                cm = ccs_in;
                if (req_nmi) cm[30] = 1'b0;
                if (m_new) begin
                    m_ccs_we = 1; m_ccs = {cm[31:30], cm[19:0], 10'd0};
                    m_exs_we = 1; m_exs = 32'(v) * 256;
                    m_dclr = (dslot_in != 0); m_lock = 0;
                end else begin
                    m_ccs_we = req_nmi; m_ccs = cm;
                    m_exs_we = 0; m_exs = 0; m_dclr = 0; m_lock = 1;
                end
                m_addr = ebp_in + 32'(v) * 4;
                m_phase = 1;
            end
            1: m_phase = m_ill ? 0 : 2;
            2: if (vt_rvalid) begin m_hdl = vt_rdata; m_phase = 3; end
            3: m_phase = 4;
            default: m_phase = 0;
        endcase
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            chk("R12", "busy in reset", 32'(busy), 0);
            chk("R12", "vt_req in reset", 32'(vt_req), 0);
        end else if (!finished) begin
            bit sv, ok;
            sv = (m_phase == 1);
            ok = sv && !m_ill;
            chk("R11", "busy", 32'(busy), 32'(m_phase != 0));
            chk("R8", "done", 32'(done), 32'(m_phase == 4));
            chk("R7", "vt_req", 32'(vt_req), 32'(m_phase == 2));
            if (m_phase == 2) chk("R1", "vt_addr", vt_addr, m_addr);
            chk("R8", "pc_we", 32'(pc_we), 32'(m_phase == 3));
            if (m_phase == 3) chk("R8", "pc_val", pc_val, m_hdl);
            chk("R10", "illegal", 32'(illegal), 32'(sv && m_ill));
            chk("R2", "nrp_we", 32'(nrp_we), 32'(ok && m_nrp));
            chk("R2", "erp_we", 32'(erp_we), 32'(ok && !m_nrp));
            if (ok) chk("R2", "ret_val", ret_val, m_ret);
            chk("R3", "usp_we", 32'(usp_we), 32'(ok && m_swap));
            chk("R3", "sp_we", 32'(sp_we), 32'(ok && m_swap));
            if (ok && m_swap) begin
                chk("R3", "usp_val", usp_val, m_usp);
                chk("R3", "sp_val", sp_val, m_sp);
            end
            chk(m_new ? "R4" : "R9", "ccs_we", 32'(ccs_we), 32'(ok && m_ccs_we));
            if (ok && m_ccs_we) chk(m_new ? "R4" : "R9", "ccs_val", ccs_val, m_ccs);
            chk("R5", "exs_we", 32'(exs_we), 32'(ok && m_exs_we));
            if (ok && m_exs_we) chk("R5", "exs_val", exs_val, m_exs);
            chk("R6", "dslot_clr", 32'(dslot_clr), 32'(ok && m_dclr));
            chk("R9", "lock_set", 32'(lock_set), 32'(ok && m_lock));
        end
    end

    task automatic set_ctx(input logic [7:0] ver, input logic [31:0] ccs,
                           input logic [1:0] ds);
        ver_in = ver; ccs_in = ccs; dslot_in = ds;
        pc_in = pc_in + 32'h0000_0124; sp_in = sp_in + 32'h40;
        ksp_in = 32'h8000_1000 ^ pc_in; ebp_in = 32'h0001_0000 + (pc_in & 32'hF00);
        trap_vec = pc_in[7:0] ^ 8'h11; fault_vec = 8'h2E; irq_vec = pc_in[9:2];
    endtask

    // reqs = {nmi, bus, brk, irq}; late_irq raises an interrupt while busy
    task automatic run(input logic [3:0] reqs, input int latency, input bit late_irq);
        int guard;
        lat = latency;
        @(negedge clk);
        {req_nmi, req_bus, req_brk, req_irq} = reqs;
        @(negedge clk);
        {req_nmi, req_bus, req_brk, req_irq} = 4'b0;
        if (late_irq) req_irq = 1;
        guard = 0;
        while (busy === 1'b1 && guard < 100) begin
            if (done === 1'b1) req_irq = 0;
            @(negedge clk);
            guard++;
        end
        req_irq = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        pc_in = 32'h0000_4000; sp_in = 32'h0000_F000;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 R3 R4 R5: irq, current set, user mode
        set_ctx(8'd40, 32'h0003_F1A5, 2'd0); run(4'b0001, 1, 0);
        // R6 R2: break in kernel with delay slot
        set_ctx(8'd32, 32'hC00A_0055, 2'd1); run(4'b0010, 0, 0);
        // R4: NMI clears M before shift
        set_ctx(8'd50, 32'h7FFF_FFFF, 2'd2); run(4'b1000, 2, 0);
        // bus fault, current set, delay slot 3
        set_ctx(8'd33, 32'h4000_0100, 2'd3); run(4'b0100, 3, 0);
        // R1 priority cases
        set_ctx(8'd40, 32'h0000_0100, 2'd1); run(4'b1111, 1, 0);
        set_ctx(8'd40, 32'h1234_5678, 2'd0); run(4'b0111, 1, 0);
        set_ctx(8'd40, 32'h8765_4321, 2'd0); run(4'b0011, 0, 0);
        // R9 legacy set
        set_ctx(8'd31, 32'h4000_0100, 2'd2); run(4'b0001, 1, 0);
        set_ctx(8'd10, 32'h4000_0000, 2'd1); run(4'b1000, 1, 0);
        // R10 legacy bus fault
        set_ctx(8'd0, 32'h0000_0100, 2'd1); run(4'b0100, 1, 0);
        // R11 request while busy is ignored
        set_ctx(8'd40, 32'h0000_0000, 2'd0); run(4'b0010, 4, 1);
        repeat (4) @(negedge clk);
        chk("R11", "idle after ignored request", 32'(busy), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual %h expected %h", 32'(busy), 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule